// File: doc/BRIEF.md
# Dual Prescaled Timebase Generator

This block produces two free-running 16-bit reference counts for the compare and capture channels of a timer subsystem. The first timebase always advances from the system clock through a power-of-two prescaler. The second timebase uses its own prescaler, and a configuration bit selects what drives it. One setting drives it from the system clock. The other drives it from rising edges on an external clock pin.

The external pin passes through a two-flop synchroniser and a rising-edge detector. A spacing filter then ignores any edge that arrives too soon after the last accepted edge, so the count cannot run faster than the pin can be sampled reliably. Each prescaler restarts from zero whenever its divide ratio or its source selection changes. Downstream channels read both counts directly from the block's outputs.

Top module: `dual_timebase`

## Requirements
- R1: While `rst_n` is low, both `count1` and `count2` read 0.
- R2: `count1` increases by one every 2^`cfg_div1` system clocks, where `cfg_div1` is an unsigned 3-bit value from 0 (divide by 1) to 7 (divide by 128). It never moves by any other amount.
- R3: When `cfg_src2` is 0, `count2` increases by one every 2^`cfg_div2` system clocks, and activity on `ext_clk` has no effect on it.
- R4: Both counts wrap from 0xFFFF to 0x0000.
- R5: A change to a prescaler's divide field, or to `cfg_src2` for the second prescaler, restarts that prescaler. If the change is present before clock edge E0, the increment that would have fallen on E0 is dropped. The next increments land on edges E(k·2^d) for k ≥ 1.
- R6: When `cfg_src2` is 1 and `cfg_div2` is 0, a rise of `ext_clk` set up before clock edge E0 makes `count2` increase at edge E2, after two synchroniser stages.
- R7: In external mode, a rising edge is counted only if at least 9 system clocks have passed since the last counted edge. Closer edges are dropped, and no edge is counted in two consecutive cycles.
- R8: In external mode, `count2` holds its value when `ext_clk` does not rise. Counted edges are divided by 2^`cfg_div2`.
- R9: `count1` is unaffected by `cfg_src2` and `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div1 | input | 3 | Divide exponent for timebase 1 (ratio 2^value) |
| cfg_div2 | input | 3 | Divide exponent for timebase 2 (ratio 2^value) |
| cfg_src2 | input | 1 | Timebase 2 source: 0 system clock, 1 external pin |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| count1 | output | 16 | Timebase 1 count |
| count2 | output | 16 | Timebase 2 count |

## Verification
All eight divide exponents are swept on both timebases, each time with a different exponent on the other timebase. Every cycle after a restart is compared with the arithmetic floor((n-1)/2^d). This separates a correct restart phase from an off-by-one or a wrong ratio. During the sweep, `ext_clk` toggles so that any leak of the pin into internal mode would show. In external mode, pulse trains with periods 9, 8 and 3 test the spacing filter at its accept/reject boundary and at a far-too-fast rate, and a period-10 train with divide-by-2 tests the prescaler fed by the pin. A single edge probes the synchroniser latency cycle by cycle, and a full 65536-step run shows the wrap.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 3;
  localparam int MIN_EDGE_GAP = 9;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    SRC_SYSCLK = 1'b0,
    SRC_PIN    = 1'b1
  } src_sel_e;
endpackage

// File: rtl/dtb_prescaler.sv
module dtb_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             mode_key,
  input  logic             en,
  output logic             tick
);
  localparam int PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [SEL_W-1:0]  sel_q;
  logic              key_q;
  logic              restart;
  logic [PCNT_W:0]   one_sh;
  logic [PCNT_W-1:0] lim;

  always_comb begin
    one_sh  = (PCNT_W+1)'(1) << sel;
    lim     = one_sh[PCNT_W-1:0] - PCNT_W'(1);
    restart = (sel != sel_q) || (mode_key != key_q);
    tick    = en && !restart && (pcnt_q == lim);
    pcnt_d  = pcnt_q;
    if (restart)   pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (en)   pcnt_d = pcnt_q + PCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sel_q  <= '0;
      key_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      sel_q  <= sel;
      key_q  <= mode_key;
    end
  end

  // R2
  no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel != '0)) |=> !tick);
endmodule

// File: rtl/dtb_ext_edge.sv
module dtb_ext_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic accept
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [GAP_W-1:0]       gap_q, gap_d;
  logic                   rise;

  always_comb begin
    rise   = sync_q[SYNC_STAGES-1] && !prev_q;
    accept = rise && (gap_q >= GAP_W'(MIN_GAP));
    gap_d  = gap_q;
    if (accept)                         gap_d = GAP_W'(1);
    else if (gap_q < GAP_W'(MIN_GAP))   gap_d = gap_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      gap_q  <= GAP_W'(MIN_GAP);
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      gap_q  <= gap_d;
    end
  end

  // R7
  accept_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
endmodule

// File: rtl/dtb_counter.sv
module dtb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (inc) count_d = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R4
  unit_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_q) |-> (count_q == W'($past(count_q) + W'(1))));
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import dtb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_div1,
  input  logic [SEL_W-1:0] cfg_div2,
  input  logic             cfg_src2,
  input  logic             ext_clk,
  output logic [CNT_W-1:0] count1,
  output logic [CNT_W-1:0] count2
);
  localparam int NBASE = 2;

  logic             ext_accept;
  logic [NBASE-1:0] base_en;
  logic [NBASE-1:0] base_key;
  logic [NBASE-1:0] base_tick;
  logic [SEL_W-1:0] base_sel [NBASE];
  logic [CNT_W-1:0] base_cnt [NBASE];
  src_sel_e         src2;

  assign src2        = src_sel_e'(cfg_src2);
  assign base_sel[0] = cfg_div1;
  assign base_sel[1] = cfg_div2;
  assign base_key    = {cfg_src2, 1'b0};
  assign base_en[0]  = 1'b1;
  assign base_en[1]  = (src2 == SRC_PIN) ? ext_accept : 1'b1;

  dtb_ext_edge #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_GAP    (MIN_EDGE_GAP)
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ext_in(ext_clk),
    .accept(ext_accept)
  );

  for (genvar i = 0; i < NBASE; i++) begin : g_base
    dtb_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (base_sel[i]),
      .mode_key(base_key[i]),
      .en      (base_en[i]),
      .tick    (base_tick[i])
    );
    dtb_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (base_tick[i]),
      .count(base_cnt[i])
    );
  end

  assign count1 = base_cnt[0];
  assign count2 = base_cnt[1];

  // R8
  pin_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src2 && $past(cfg_src2) && !$past(ext_clk) && !$past(ext_clk, 2)
     && !$past(ext_clk, 3) && !$past(ext_clk, 4)) |-> $stable(count2));
endmodule

// File: tb/dual_timebase_test.sv
module dual_timebase_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_div1, cfg_div2;
  logic        cfg_src2;
  logic        ext_clk;
  logic [15:0] count1, count2;

  int vectors = 0;
  int errors  = 0;
  int steps   = 0;

  dual_timebase uut (
    .clk(clk), .rst_n(rst_n), .cfg_div1(cfg_div1), .cfg_div2(cfg_div2),
    .cfg_src2(cfg_src2), .ext_clk(ext_clk), .count1(count1), .count2(count2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    steps++;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int p = 0; p < n; p++) begin
      ext_clk = 1'b1;
      repeat (hi) step();
      ext_clk = 1'b0;
      repeat (lo) step();
    end
    repeat (12) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] c1, c2;
    int lim;
    rst_n = 1'b0; cfg_div1 = 3'd0; cfg_div2 = 3'd0; cfg_src2 = 1'b0; ext_clk = 1'b0;
    repeat (3) step();
    // R1: counts held at zero in reset
    check(count1 == 16'd0, "R1 count1", count1, 0);
    check(count2 == 16'd0, "R1 count2", count2, 0);
    rst_n = 1'b1;
    cfg_div1 = 3'd7; cfg_div2 = 3'd7;
    repeat (4) step();

    // R2 R3 R5: sweep every exponent, both timebases, ext toggling
    for (int d = 0; d < 8; d++) begin
      cfg_div1 = 3'(d);
      cfg_div2 = 3'(7 - d);
      c1 = count1; c2 = count2;
      for (int n = 1; n <= 3 * (1 << d) + 1; n++) begin
        ext_clk = ~ext_clk;
        step();
        // R2 R5
        check(count1 == 16'(c1 + ((n - 1) >> d)), "R2/R5 count1", count1, 16'(c1 + ((n - 1) >> d)));
        // R3 R5
        check(count2 == 16'(c2 + ((n - 1) >> (7 - d))), "R3/R5 count2", count2, 16'(c2 + ((n - 1) >> (7 - d))));
      end
    end
    ext_clk = 1'b0;

    // R4: wrap
    cfg_div1 = 3'd0;
    step();
    lim = 0;
    while (count1 != 16'hFFFF && lim < 70000) begin step(); lim++; end
    check(count1 == 16'hFFFF, "R4 reach max", count1, 16'hFFFF);
    step();
    check(count1 == 16'h0000, "R4 wrap", count1, 0);

    // External mode; count1 runs at divide-by-4 throughout (R9)
    cfg_div1 = 3'd2; cfg_div2 = 3'd0; cfg_src2 = 1'b1;
    c1 = count1; steps = 0;
    repeat (20) step();
    // R8: no edges, hold
    c2 = count2;
    repeat (30) step();
    check(count2 == c2, "R8 hold", count2, c2);

    // R6: latency of a single edge
    ext_clk = 1'b1;
    step();
    check(count2 == c2, "R6 after E0", count2, c2);
    step();
    check(count2 == c2, "R6 after E1", count2, c2);
    step();
    check(count2 == 16'(c2 + 1), "R6 after E2", count2, 16'(c2 + 1));
    ext_clk = 1'b0;
    repeat (12) step();

    // R7: period 9 all counted
    c2 = count2;
    pulses(10, 4, 5);
    check(count2 == 16'(c2 + 10), "R7 period 9", count2, 16'(c2 + 10));
    // R7: period 8 every other counted
    c2 = count2;
    pulses(10, 4, 4);
    check(count2 == 16'(c2 + 5), "R7 period 8", count2, 16'(c2 + 5));
    // R7: period 3, one in three counted
    c2 = count2;
    pulses(12, 1, 2);
    check(count2 == 16'(c2 + 4), "R7 period 3", count2, 16'(c2 + 4));

    // R8: prescaler on pin edges, divide by 2
    cfg_div2 = 3'd1;
    repeat (3) step();
    c2 = count2;
    pulses(8, 5, 5);
    check(count2 == 16'(c2 + 4), "R8 pin divide", count2, 16'(c2 + 4));

    // R9: count1 unaffected by external activity
    check(count1 == 16'(c1 + ((steps - 1) >> 2)), "R9 count1", count1, 16'(c1 + ((steps - 1) >> 2)));

    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #(CLK_PERIOD/8);
    check(count1 == 16'd0, "R1 async count1", count1, 0);
    check(count2 == 16'd0, "R1 async count2", count2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule